// File: doc/BRIEF.md
# DMA Command Queue Register Block

This block is the register file on the host side of a DMA command queue. Software reaches it over a simple 32-bit register bus addressed by byte offset. It holds the queue base, the end pointer, the write pointer, the read pointer, an interrupt enable word and an interrupt status word. It drives one level-sensitive interrupt line. The data movement itself happens elsewhere.

Writing the write pointer reports that a transfer has finished in both directions. The block sets both completion flags and raises the interrupt if either completion enable is on. The written pointer is also mirrored into the read pointer. Software can suppress exactly one such report. It does this by first writing a fixed key value to the read pointer. The read pointer itself can never be written directly. Any write to the status word that carries either completion bit clears both completion bits together and drops the interrupt.

The decoded window is 4 KiB. Only its first 32 words hold storage. Accesses are always full 32-bit words, and the two low address bits are ignored. A write completes in the cycle it is presented. Read data appears on `rdata` one clock after `re`. When `re` and `we` are both high in the same cycle, the read returns the value from before the write.

Top module: `cmdq_regs`

## Requirements
- R1: After reset every word reads zero except the status word (offset 0x24), which reads 0xF8000000. The interrupt is low and the skip token is disarmed.
- R2: Read data for an access with `re` high appears on `rdata` after the next rising clock edge. Offsets from 0x80 up to 0xFFC read as zero, and writes to them change no stored word.
- R3: Writes to the end pointer (0x14) and the write pointer (0x18) store only bits 17:0 of the data. The upper bits read as zero.
- R4: A write to the write pointer also stores the same masked value into the read pointer (0x1C).
- R5: A write to the read pointer never changes its stored value. A write of exactly 0xEE882266 arms the skip token.
- R6: A write-pointer write while the skip token is armed disarms the token. It leaves the status word and the interrupt unchanged. The token covers one such write only.
- R7: A write-pointer write with the token disarmed sets status bits 4 and 5. It raises the interrupt if enable bit 4 or bit 5 (offset 0x20) is set.
- R8: Writes to the enable word (0x20) store the data ANDed with 0xBFEFF07F.
- R9: A status write whose data has bit 4 or bit 5 set clears both status bits 4 and 5 and lowers the interrupt. Other status bits keep their value. A status write with neither bit set changes nothing.
- R10: Every other offset inside the first 32 words is plain read/write storage. This includes the queue base at 0x10.
- R11: The interrupt is a registered level. It holds until a clearing status write or reset, and a write to the enable word alone never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, accepted in one cycle |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data, valid one cycle after `re` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the interplay of the one-shot skip token with completion and clearing. An armed token must swallow exactly one write-pointer write, even when enables are on and an interrupt is already pending. The token is invisible at the ports, so the bench tracks it in a reference model. The random stimulus is biased toward the queue pointers, and about a third of the read-pointer writes carry the key value. This produces armed-token writes, repeated arming and clears mixed with enable changes. Directed sequences add the exact boundary cases on top.

// File: rtl/cmdq_regs.sv
module cmdq_regs #(
  parameter int          ADDR_W   = 12,
  parameter int          NWORDS   = 32,
  parameter logic [31:0] SKIP_KEY = 32'hEE88_2266
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  input  logic              re,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int IDX_W = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] W_END = IDX_W'(5);
  localparam logic [IDX_W-1:0] W_WP  = IDX_W'(6);
  localparam logic [IDX_W-1:0] W_RP  = IDX_W'(7);
  localparam logic [IDX_W-1:0] W_CTL = IDX_W'(8);
  localparam logic [IDX_W-1:0] W_ST  = IDX_W'(9);
  localparam logic [31:0] PTR_MASK = 32'h0003_FFFF;
  localparam logic [31:0] CTL_MASK = 32'hBFEF_F07F;
  localparam logic [31:0] CMP_BITS = 32'h0000_0030;
  localparam logic [31:0] ST_RST   = 32'hF800_0000;

  logic [31:0]      mem [NWORDS];
  logic             skip;
  logic [IDX_W-1:0] idx;
  logic             in_rng;
  logic             unused_lsb;

  assign idx        = addr[IDX_W+1:2];
  assign in_rng     = (addr[ADDR_W-1:IDX_W+2] == '0);
  assign unused_lsb = ^addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
      mem[W_ST] <= ST_RST;
      skip      <= 1'b0;
      irq       <= 1'b0;
      rdata     <= '0;
    end else begin
      if (re) rdata <= in_rng ? mem[idx] : '0;
      if (we && in_rng) begin
        case (idx)
          W_END: mem[W_END] <= wdata & PTR_MASK;
          W_WP: begin
            mem[W_WP] <= wdata & PTR_MASK;
            mem[W_RP] <= wdata & PTR_MASK;
            if (skip) skip <= 1'b0;
            else begin
              mem[W_ST] <= mem[W_ST] | CMP_BITS;
              if (|(mem[W_CTL] & CMP_BITS)) irq <= 1'b1;
            end
          end
          W_RP:  if (wdata == SKIP_KEY) skip <= 1'b1;
          W_CTL: mem[W_CTL] <= wdata & CTL_MASK;
          W_ST: if (|(wdata & CMP_BITS)) begin
            mem[W_ST] <= mem[W_ST] & ~CMP_BITS;
            irq       <= 1'b0;
          end
          default: mem[idx] <= wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdq_regs_chk.sv
module cmdq_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int NWORDS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              we,
  input logic              irq,
  input logic              skip,
  input logic [31:0]       wptr,
  input logic [31:0]       rptr,
  input logic [31:0]       stat
);
  localparam int IDX_W = $clog2(NWORDS);
  logic [IDX_W-1:0] w;
  logic ok, hit_wp, hit_rp, hit_ctl, hit_st;
  assign w       = addr[IDX_W+1:2];
  assign ok      = we && (addr[ADDR_W-1:IDX_W+2] == '0);
  assign hit_wp  = ok && (w == IDX_W'(6));
  assign hit_rp  = ok && (w == IDX_W'(7));
  assign hit_ctl = ok && (w == IDX_W'(8));
  assign hit_st  = ok && (w == IDX_W'(9));

  AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit_wp)); // R7
  AST_IRQ_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(hit_st && (wdata[5:4] != 2'b00))); // R9
  AST_CTRL_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |=> $stable(irq)); // R11
  AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rp |=> $stable(rptr)); // R5
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wp && skip) |=> ($stable(irq) && $stable(stat[5:4]) && !skip)); // R6
  AST_PTR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    wptr[31:18] == 14'd0); // R3
  AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wp |=> (rptr == wptr)); // R4
endmodule

bind cmdq_regs cmdq_regs_chk #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
  .irq(irq), .skip(skip), .wptr(mem[W_WP]), .rptr(mem[W_RP]), .stat(mem[W_ST])
);

// File: tb/tb_cmdq_regs.sv
`timescale 1ns/1ps
module tb_cmdq_regs;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0, irq;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [31:0] m [32];
  bit mskip, mirq;

  always #2.5 clk = ~clk;

  cmdq_regs dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                 .we(we), .re(re), .rdata(rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic mdl_reset();
    for (int i = 0; i < 32; i++) m[i] = 32'h0;
    m[9] = 32'hF800_0000; mskip = 0; mirq = 0;
  endtask

  function automatic logic [31:0] mdl_read(input logic [11:0] a);
    return (a < 12'h080) ? m[a[6:2]] : 32'h0;
  endfunction

  task automatic mdl_write(input logic [11:0] a, input logic [31:0] d);
    int k;
    if (a >= 12'h080) return;
    k = a[6:2];
    if (k == 5) m[5] = d & 32'h3FFFF;
    else if (k == 6) begin
      m[6] = d & 32'h3FFFF; m[7] = m[6];
      if (mskip) mskip = 0;
      else begin
        m[9] = m[9] | 32'h30;
        if (m[8][4] || m[8][5]) mirq = 1;
      end
    end else if (k == 7) begin
      if (d == 32'hEE88_2266) mskip = 1;
    end else if (k == 8) m[8] = d & 32'hBFEF_F07F;
    else if (k == 9) begin
      if (d[4] || d[5]) begin m[9] = m[9] & ~32'h30; mirq = 0; end
    end else m[k] = d;
  endtask

  function automatic string tag_of(input logic [11:0] a);
    if (a >= 12'h080) return "R2";
    case (a[6:2])
      5, 6: return "R3";
      7: return "R4";
      8: return "R8";
      9: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
    mdl_write(a, d);
    chk(tag, {31'h0, irq}, {31'h0, mirq});
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk); addr = a; re = 1;
    @(negedge clk); re = 0;
    chk(tag, rdata, mdl_read(a));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%08h exp=%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    mdl_reset();
    #12 rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    for (int i = 0; i < 32; i++) rd(12'(i * 4), "R1");
    chk("R1 status", m[9], 32'hF800_0000);

    // R2 out of range and latency
    wr(12'h080, 32'hDEAD_BEEF, "R2");
    wr(12'hFFC, 32'h1234_5678, "R2");
    rd(12'h080, "R2"); rd(12'hFFC, "R2"); rd(12'h000, "R2");
    // R10 plain storage
    wr(12'h010, 32'hA5A5_5A5A, "R10"); rd(12'h010, "R10");
    wr(12'h07C, 32'hFFFF_FFFF, "R10"); rd(12'h07C, "R10");
    // R3 masks
    wr(12'h014, 32'hFFFF_FFFF, "R3"); rd(12'h014, "R3");
    chk("R3 end", m[5], 32'h0003_FFFF);
    // R4 mirror, R7 status with enables off
    wr(12'h018, 32'h1234_5678, "R4"); rd(12'h01C, "R4"); rd(12'h024, "R7");
    chk("R7 status", mdl_read(12'h024), 32'hF800_0030);
    // R8 enable mask
    wr(12'h020, 32'hFFFF_FFFF, "R8"); rd(12'h020, "R8");
    chk("R8 ctl", m[8], 32'hBFEF_F07F);
    // R9 clear, R7 raise with enable bit 4
    wr(12'h024, 32'hFFFF_FFCF, "R9"); rd(12'h024, "R9");
    wr(12'h024, 32'h0000_0020, "R9"); rd(12'h024, "R9");
    wr(12'h020, 32'h0000_0010, "R8");
    wr(12'h018, 32'h0000_0001, "R7");
    chk("R7 irq", {31'h0, irq}, 32'h1);
    // R11 enable write does not move irq
    wr(12'h020, 32'h0, "R11");
    chk("R11 irq held", {31'h0, irq}, 32'h1);
    wr(12'h024, 32'h0000_0001, "R9");
    chk("R9 no-op", {31'h0, irq}, 32'h1);
    wr(12'h024, 32'h0000_0010, "R9");
    chk("R9 irq low", {31'h0, irq}, 32'h0);
    wr(12'h020, 32'h0000_0030, "R11");
    chk("R11 irq stays low", {31'h0, irq}, 32'h0);
    // R5 and R6 skip token
    rd(12'h01C, "R5");
    wr(12'h01C, 32'hEE88_2266, "R5"); rd(12'h01C, "R5");
    wr(12'h01C, 32'h0000_1111, "R5"); rd(12'h01C, "R5");
    wr(12'h018, 32'h0000_0222, "R6");
    chk("R6 irq", {31'h0, irq}, 32'h0);
    rd(12'h024, "R6");
    chk("R6 status", mdl_read(12'h024), 32'hF800_0000);
    wr(12'h018, 32'h0000_0333, "R6");
    chk("R6 one-shot", {31'h0, irq}, 32'h1);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int sel;
      logic [11:0] a;
      logic [31:0] d;
      sel = int'($urandom % 16);
      if (sel < 10) a = 12'(((sel % 6) + 4) * 4);
      else if (sel < 14) a = 12'(($urandom % 32) * 4);
      else a = 12'h080 + 12'(($urandom % 992) * 4);
      d = $urandom;
      if (a == 12'h01C && ($urandom % 3) == 0) d = 32'hEE88_2266;
      if (a == 12'h024 && ($urandom % 2) == 0) d = d & 32'hFFFF_FFCF;
      if ($urandom % 2) wr(a, d, "R11"); else rd(a, tag_of(a));
    end
    for (int i = 0; i < 32; i++) rd(12'(i * 4), tag_of(12'(i * 4)));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule